// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block sits between two parallel buses, called A and B, and moves data in one direction at a time. Each side has its own holding register, loaded by its own capture clock. The driven bus carries either the live value of the opposite bus or the value held in the opposite side's register. An active-low enable and a direction input decide which bus, if either, is driven.

The pads are not modelled as tri-state nets. Each bus has its own input vector, output vector and per-bit output-enable vector, so the block synthesizes without internal high-impedance logic. The output data path is combinational from the selects and the live inputs. Only the held value passes through a flip-flop.

Each register captures its bus on every rising edge of its clock, whatever the enable and direction. A synchronous active-high reset clears each register. Each register samples reset on its own clock.

Top module: `xcvr_reg2way`

## Requirements
- R1: While `rst` is high, each rising edge of a register's own clock clears that register to zero. After reset, the zeros appear on `b_out` when `b_src_reg`=1 and on `a_out` when `a_src_reg`=1.
- R2: Every rising edge of `clk_a` with `rst` low loads `a_in` into the A-side register, whatever the values of `en_n`, `dir_to_b` and the selects.
- R3: Every rising edge of `clk_b` with `rst` low loads `b_in` into the B-side register, whatever the values of `en_n`, `dir_to_b` and the selects.
- R4: When `en_n`=1, both `a_oe` and `b_oe` are all zeros.
- R5: When `en_n`=0 and `dir_to_b`=1, `b_oe` is all ones and `a_oe` is all zeros.
- R6: When `en_n`=0 and `dir_to_b`=0, `a_oe` is all ones and `b_oe` is all zeros.
- R7: When `b_src_reg`=0, `b_out` equals the present `a_in`. When `b_src_reg`=1, `b_out` equals the A-side register. A new value loaded into that register appears on `b_out` after the same `clk_a` edge.
- R8: When `a_src_reg`=0, `a_out` equals the present `b_in`. When `a_src_reg`=1, `a_out` equals the B-side register. Edges of `clk_a` do not disturb that value.
- R9: `a_oe` and `b_oe` never have bits set at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Capture clock of the A-side register, rising edge |
| clk_b | input | 1 | Capture clock of the B-side register, rising edge |
| rst | input | 1 | Synchronous active-high reset, sampled on each capture clock |
| en_n | input | 1 | Active-low output enable for both buses |
| dir_to_b | input | 1 | 1: drive bus B; 0: drive bus A |
| b_src_reg | input | 1 | Source for B output: 0 live `a_in`, 1 A-side register |
| a_src_reg | input | 1 | Source for A output: 0 live `b_in`, 1 B-side register |
| a_in | input | WIDTH | Value present on bus A |
| b_in | input | WIDTH | Value present on bus B |
| a_out | output | WIDTH | Data to drive onto bus A |
| a_oe | output | WIDTH | Per-bit drive enable for bus A |
| b_out | output | WIDTH | Data to drive onto bus B |
| b_oe | output | WIDTH | Per-bit drive enable for bus B |

## Verification
The assertions assume four things about the inputs:
- Bus data and controls are steady at each capture edge.
- `rst` is held through at least one edge of each clock before release.
- The enable checks sample on `clk_a`, so they assume the controls do not change in a way that escapes those edges.
- The capture checks take for granted that no edge arrives while the bus is changing.

The bench satisfies these assumptions:
- It runs the A clock free.
- It changes every input only at the falling edge of that clock.
- It pulses the B clock by hand, inside the low half of the A clock, while `b_in` is held.
- It sweeps all sixteen control combinations against several data patterns.
- It replaces each bus value after capture, so that live and held data always differ.

// File: rtl/xcvr_reg2way.sv
module xcvr_reg2way #(
  parameter int WIDTH = 8
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             rst,
  input  logic             en_n,
  input  logic             dir_to_b,
  input  logic             b_src_reg,
  input  logic             a_src_reg,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);

  logic [WIDTH-1:0] hold_a;
  logic [WIDTH-1:0] hold_b;
  logic             drive_a;
  logic             drive_b;

  always_ff @(posedge clk_a)
    if (rst) hold_a <= '0;
    else     hold_a <= a_in;

  always_ff @(posedge clk_b)
    if (rst) hold_b <= '0;
    else     hold_b <= b_in;

  assign drive_b = ~en_n &  dir_to_b;
  assign drive_a = ~en_n & ~dir_to_b;

  assign b_oe  = {WIDTH{drive_b}};
  assign a_oe  = {WIDTH{drive_a}};
  assign b_out = b_src_reg ? hold_a : a_in;
  assign a_out = a_src_reg ? hold_b : b_in;

  AST_CAPTURE_A: assert property (@(posedge clk_a) disable iff (rst)
    1'b1 |=> (hold_a == $past(a_in)));                                   // R2

  AST_CAPTURE_B: assert property (@(posedge clk_b) disable iff (rst)
    1'b1 |=> (hold_b == $past(b_in)));                                   // R3

  AST_ISOLATED: assert property (@(posedge clk_a) disable iff (rst)
    en_n |-> (a_oe == '0 && b_oe == '0));                                // R4

  AST_DRIVE_B: assert property (@(posedge clk_a) disable iff (rst)
    (!en_n && dir_to_b) |-> (&b_oe && a_oe == '0));                      // R5

  AST_DRIVE_A: assert property (@(posedge clk_a) disable iff (rst)
    (!en_n && !dir_to_b) |-> (&a_oe && b_oe == '0));                     // R6

  AST_ONE_SIDE: assert property (@(posedge clk_a) disable iff (rst)
    !((|a_oe) && (|b_oe)));                                              // R9

endmodule

// File: tb/test_xcvr_reg2way.sv
module test_xcvr_reg2way;
  localparam int W = 8;

  logic         clk_a = 1'b0;
  logic         clk_b = 1'b0;
  logic         rst = 1'b1;
  logic         en_n = 1'b1;
  logic         dir_to_b = 1'b0;
  logic         b_src_reg = 1'b0;
  logic         a_src_reg = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #4 clk_a = ~clk_a;

  xcvr_reg2way #(.WIDTH(W)) i_xcvr_reg2way (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .en_n(en_n), .dir_to_b(dir_to_b),
    .b_src_reg(b_src_reg), .a_src_reg(a_src_reg), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_b();
    #1 clk_b = 1'b1;
    #1 clk_b = 1'b0;
  endtask

  initial begin
    @(negedge clk_a);
    pulse_b();
    pulse_b();
    @(negedge clk_a);
    en_n = 1'b0; dir_to_b = 1'b1; b_src_reg = 1'b1; a_src_reg = 1'b1;
    a_in = 8'hA5; b_in = 8'h5A;
    pulse_b();
    @(negedge clk_a);
    rst = 1'b0;
    #1;
    chk("R1 b_out after reset", b_out, '0);
    chk("R1 a_out after reset", a_out, '0);

    for (int i = 0; i < 8; i++) begin
      for (int c = 0; c < 16; c++) begin
        logic [W-1:0] pa, pb, na, nb;
        logic e, d, sb, sa;
        e = c[0]; d = c[1]; sb = c[2]; sa = c[3];
        pa = W'(i * 37 + c * 13 + 5);
        pb = W'(i * 91 + c * 7 + 3);
        na = ~pa;
        nb = pb ^ 8'h3C;
        @(negedge clk_a);
        en_n = e; dir_to_b = d; b_src_reg = sb; a_src_reg = sa;
        a_in = pa; b_in = pb;
        pulse_b();
        @(negedge clk_a);
        a_in = na; b_in = nb;
        #1;
        chk("R4/R5 b_oe", b_oe, {W{~e & d}});
        chk("R4/R6 a_oe", a_oe, {W{~e & ~d}});
        chk("R9 exclusive", W'((|a_oe) & (|b_oe)), '0);
        chk("R7 b_out R2", b_out, sb ? pa : na);
        chk("R8 a_out R3", a_out, sa ? pb : nb);
      end
    end

    @(negedge clk_a);
    en_n = 1'b1; dir_to_b = 1'b0; b_src_reg = 1'b1; a_src_reg = 1'b1;
    a_in = 8'hC3; b_in = 8'h81;
    pulse_b();
    @(negedge clk_a);
    en_n = 1'b0;
    #1;
    chk("R2 captured while isolated", b_out, 8'hC3);
    chk("R3 captured while isolated", a_out, 8'h81);
    b_in = 8'h18;
    @(negedge clk_a);
    @(negedge clk_a);
    #1;
    chk("R8 held across clk_a edges", a_out, 8'h81);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule